// File: doc/BRIEF.md
# Cascadable Fall-Through FIFO Stage

This block is a single-clock FIFO whose head word is presented on the output without any read request: as soon as a word is readable, it is placed on the data output and the active-low output-ready flag drops. On the write side, an active-low input-ready flag is low whenever a free location exists and a write will be taken. Writes and reads are requested with active-low enables. An active-low synchronous master reset empties the stage.

The flags are shaped so that stages can be wired in series with no glue. A stage's data output goes to the next stage's data input. Its output-ready drives the next stage's write enable. The next stage's input-ready drives its read enable. Words then move forward and free slots move backward on their own, and the chain acts as one FIFO whose capacity is the sum of the stage capacities.

The per-stage latencies are fixed. A word needs three clock edges from its write to reach the outputs of an empty stage. A freed slot needs two edges from its read to show on input-ready. In a chain, each extra stage therefore adds four edges to the first-word fall-through time and three edges to the free-slot return time. Once a word is waiting behind the head word, back-to-back reads stream with no gap.

Top module: `cff_stage`

## Requirements
- R1: While master reset is low at a clock edge, the stage empties; after that edge output-ready is high and input-ready is low.
- R2: A word written into an empty stage appears on the data output with output-ready low after the third clock edge counted from the write edge, with no read requested.
- R3: Words leave the stage, and a chain of stages, in the order they were accepted.
- R4: A stage holds exactly DEPTH words. A write requested while input-ready is high is ignored: it is not stored and does not disturb the stored words.
- R5: A read requested while output-ready is high is ignored and does not disturb the words that follow.
- R6: In a full stage, input-ready goes low after the second clock edge counted from the edge that reads a word.
- R7: While output-ready is low and no read is requested, the data output holds its word. If further words are readable, each read is followed at once by the next word, with output-ready staying low.
- R8: Two chained stages hold 2*DEPTH words. A first word written into the empty chain reaches the last stage's outputs 7 edges after its write edge. Reading a full chain makes the first stage's input-ready drop 5 edges after the read edge.
- R9: Input-ready goes high after the edge of the write that fills the stage, so no write can ever overflow it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides and by all chained stages |
| mrst_n | input | 1 | Synchronous active-low master reset |
| din | input | WIDTH | Write data |
| wen_n | input | 1 | Active-low write request |
| ir_n | output | 1 | Active-low input-ready: a free location exists |
| ren_n | input | 1 | Active-low read request (pops the word on dout) |
| dout | output | WIDTH | Head word, valid while or_n is low |
| or_n | output | 1 | Active-low output-ready: dout holds a valid word |

## Verification
The hardest condition to reach from the ports is a free slot travelling backward through a completely full chain. To get there, the bench keeps the last stage's read enable high and writes into the chain until no more writes are taken for many cycles, which shows that both stages are full. It then issues exactly one read and counts edges until the first stage's input-ready drops. The fall-through measurement mirrors this on an empty chain. A random phase then toggles both ends while a queue model checks each word leaving the chain.

// File: rtl/cff_pkg.sv
// Package: shared latency constants for the fall-through FIFO stage.
// Assumes: the values below are fixed by the chaining contract and must
// not be changed independently of the flag timing the users rely on.
package cff_pkg;
    // Edges between write acceptance and the word becoming loadable.
    localparam int SHOW_LAT = 2;
    // Edges between a read and the freed slot reaching the fill count.
    localparam int FREE_LAT = 2;
endpackage

// File: rtl/cff_dly.sv
// Module: cff_dly - fixed pulse delay line of STAGES flops.
// Assumes: synchronous active-low reset clears every flop; STAGES >= 0.
module cff_dly #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    output logic pulse_out
);
    generate
        if (STAGES == 0) begin : g_wire
            assign pulse_out = pulse_in;
        end else begin : g_chain
            logic [STAGES-1:0] taps;
            // Shift the pulse one flop per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) taps <= '0;
                else        taps <= {taps[STAGES-2 >= 0 ? STAGES-2 : 0:0], pulse_in};
            end
            assign pulse_out = taps[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/cff_ram.sv
// Module: cff_ram - word storage with a synchronous write port and an
// asynchronous read port.
// Assumes: addresses are always below DEPTH; no reset on contents.
module cff_ram #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    // Store one word per accepted write.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/cff_stage.sv
// Module: cff_stage - single-clock FIFO stage with fall-through output
// and active-low ready flags, wired in series without glue logic.
// Assumes: one clock for write and read; the clock runs freely so that
// chained stages keep moving words; DEPTH >= 2.
module cff_stage #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             wen_n,
    output logic             ir_n,
    input  logic             ren_n,
    output logic [WIDTH-1:0] dout,
    output logic             or_n
);
    import cff_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_ADR = AW'(DEPTH - 1);

    logic             wr_fire, rd_fire, load;
    logic             wr_late, rd_late;
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    fill, fill_next;
    logic [CW-1:0]    vis, vis_next;
    logic [WIDTH-1:0] head_word;

    assign wr_fire = !wen_n && !ir_n;
    assign rd_fire = !ren_n && !or_n;
    assign load    = (vis != '0) && (or_n || rd_fire);

    cff_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(wr_fire), .waddr(wptr), .wdata(din),
        .raddr(rptr), .rdata(head_word)
    );

    cff_dly #(.STAGES(SHOW_LAT)) u_show (
        .clk(clk), .rst_n(mrst_n), .pulse_in(wr_fire), .pulse_out(wr_late)
    );

    cff_dly #(.STAGES(FREE_LAT)) u_free (
        .clk(clk), .rst_n(mrst_n), .pulse_in(rd_fire), .pulse_out(rd_late)
    );

    // Occupancy seen by the writer: grows on write, shrinks when a freed slot matures.
    always_comb begin
        fill_next = fill;
        if (wr_fire && !rd_late)      fill_next = fill + 1'b1;
        else if (!wr_fire && rd_late) fill_next = fill - 1'b1;
    end

    // Words in storage that may be moved to the output register.
    always_comb begin
        vis_next = vis;
        if (wr_late && !load)      vis_next = vis + 1'b1;
        else if (!wr_late && load) vis_next = vis - 1'b1;
    end

    // Write pointer and input-ready flag.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            wptr <= '0;
            fill <= '0;
            ir_n <= 1'b0;
        end else begin
            if (wr_fire) wptr <= (wptr == LAST_ADR) ? '0 : wptr + 1'b1;
            fill <= fill_next;
            ir_n <= (fill_next == FULL_CNT);
        end
    end

    // Read pointer, fall-through output register and output-ready flag.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            rptr <= '0;
            vis  <= '0;
            or_n <= 1'b1;
            dout <= '0;
        end else begin
            vis <= vis_next;
            if (load) begin
                dout <= head_word;
                or_n <= 1'b0;
                rptr <= (rptr == LAST_ADR) ? '0 : rptr + 1'b1;
            end else if (rd_fire) begin
                or_n <= 1'b1;
            end
        end
    end

    // R1: reset leaves the stage empty with the flags in their idle levels.
    p_reset_flags_r1: assert property (@(posedge clk)
        !mrst_n |=> (or_n && !ir_n));

    // R2: a write into an empty stage cannot show on the next edge.
    p_no_early_show_r2: assert property (@(posedge clk) disable iff (!mrst_n)
        (wr_fire && fill == '0) |=> or_n);

    // R4: occupancy never exceeds the capacity.
    p_fill_range_r4: assert property (@(posedge clk) disable iff (!mrst_n)
        fill <= FULL_CNT);

    // R5: a read with no valid word, and nothing maturing, leaves the output empty.
    p_idle_read_r5: assert property (@(posedge clk) disable iff (!mrst_n)
        (or_n && !ren_n && vis == '0 && !wr_late) |=> or_n);

    // R7: an unread valid word is held unchanged.
    p_hold_word_r7: assert property (@(posedge clk) disable iff (!mrst_n)
        (!or_n && ren_n) |=> (!or_n && $stable(dout)));

    // R9: an accepted write always finds room.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!mrst_n)
        wr_fire |-> (fill < FULL_CNT));
endmodule

// File: tb/sim_cff_stage.sv
module sim_cff_stage;
    localparam int PERIOD = 10;
    localparam int W = 18;
    localparam int D = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    // standalone stage
    logic [W-1:0] s_din = '0, s_dout;
    logic s_wen_n = 1'b1, s_ren_n = 1'b1, s_ir_n, s_or_n;
    // two-stage chain
    logic [W-1:0] c_din = '0, m_dout, c_dout;
    logic c_wen_n = 1'b1, c_ren_n = 1'b1, c_ir_n, c_or_n, m_ir_n, m_or_n, l_ir_n;

    cff_stage #(.WIDTH(W), .DEPTH(D)) u0 (
        .clk(clk), .mrst_n(rst_n), .din(s_din), .wen_n(s_wen_n), .ir_n(s_ir_n),
        .ren_n(s_ren_n), .dout(s_dout), .or_n(s_or_n));
    cff_stage #(.WIDTH(W), .DEPTH(D)) u1 (
        .clk(clk), .mrst_n(rst_n), .din(c_din), .wen_n(c_wen_n), .ir_n(c_ir_n),
        .ren_n(l_ir_n), .dout(m_dout), .or_n(m_or_n));
    cff_stage #(.WIDTH(W), .DEPTH(D)) u2 (
        .clk(clk), .mrst_n(rst_n), .din(m_dout), .wen_n(m_or_n), .ir_n(l_ir_n),
        .ren_n(c_ren_n), .dout(c_dout), .or_n(c_or_n));
    assign m_ir_n = l_ir_n;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic [W-1:0] q_s[$];
    logic [W-1:0] q_c[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model: queues updated and compared at every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!s_or_n) begin
                if (q_s.size() == 0) chk(0, "R3 standalone word with empty model", 1, 0);
                else begin
                    chk(s_dout == q_s[0], "R3 standalone order", s_dout, q_s[0]);
                    if (!s_ren_n) void'(q_s.pop_front());
                end
            end
            if (!s_wen_n && !s_ir_n) q_s.push_back(s_din);
            if (!c_or_n) begin
                if (q_c.size() == 0) chk(0, "R3 chain word with empty model", 1, 0);
                else begin
                    chk(c_dout == q_c[0], "R3 chain order", c_dout, q_c[0]);
                    if (!c_ren_n) void'(q_c.pop_front());
                end
            end
            if (!c_wen_n && !c_ir_n) q_c.push_back(c_din);
        end
    end

    // Edges from the request edge until the selected flag is low.
    task automatic edges_to_low(input int sel, output int n);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if ((sel == 0 && !s_or_n) || (sel == 1 && !s_ir_n) ||
                (sel == 2 && !c_or_n) || (sel == 3 && !c_ir_n)) break;
            @(posedge clk); #2;
            n++;
        end
    endtask

    task automatic step(input int k);
        repeat (k) @(posedge clk);
        #2;
    endtask

    initial begin
        int n, acc, gaps, idle;
        step(3);
        @(negedge clk);
        chk(s_or_n && !s_ir_n, "R1 standalone flags after reset", {s_or_n, s_ir_n}, 2);
        chk(c_or_n && !c_ir_n && m_or_n, "R1 chain flags after reset", {c_or_n, c_ir_n}, 2);
        @(posedge clk); #2; rst_n = 1'b1;
        step(2);

        // R5: read on an empty stage is ignored
        s_ren_n = 1'b0; step(1); s_ren_n = 1'b1; step(2);
        @(negedge clk);
        chk(s_or_n, "R5 empty read leaves or_n high", s_or_n, 1);

        // R2: fall-through latency of one stage
        @(posedge clk); #2;
        s_din = 18'h155; s_wen_n = 1'b0;
        @(posedge clk); #2; s_wen_n = 1'b1;
        edges_to_low(0, n);
        chk(n == 3, "R2 stage fall-through edges", n, 3);
        chk(s_dout == 18'h155, "R2 word on output without read", s_dout, 18'h155);
        @(posedge clk); #2; s_ren_n = 1'b0; step(1); s_ren_n = 1'b1; step(4);

        // R4/R9: fill the stage and push extra writes
        acc = 0;
        for (int i = 0; i < D + 3; i++) begin
            s_din = W'(100 + i); s_wen_n = 1'b0;
            if (!s_ir_n) acc++;
            step(1);
        end
        s_wen_n = 1'b1; step(6);
        @(negedge clk);
        chk(acc == D, "R4 stage accepts DEPTH words", acc, D);
        chk(s_ir_n, "R9 ir_n high when full", s_ir_n, 1);
        chk(q_s.size() == D, "R4 ignored writes not stored", q_s.size(), D);

        // R6: free slot returns after two edges
        @(posedge clk); #2; s_ren_n = 1'b0;
        @(posedge clk); #2; s_ren_n = 1'b1;
        edges_to_low(1, n);
        chk(n == 2, "R6 free slot edges", n, 2);

        // R7: streaming reads without gaps
        @(posedge clk); #2;
        gaps = 0;
        s_ren_n = 1'b0;
        for (int i = 0; i < D - 1; i++) begin
            @(negedge clk); if (s_or_n) gaps++;
            @(posedge clk); #2;
        end
        s_ren_n = 1'b1; step(2);
        chk(gaps == 0, "R7 back-to-back reads", gaps, 0);
        chk(q_s.size() == 0, "R7 stage drained", q_s.size(), 0);
        @(negedge clk);
        chk(s_or_n, "R7 or_n high when empty", s_or_n, 1);

        // R8: chain fall-through latency
        @(posedge clk); #2;
        c_din = 18'h2aa; c_wen_n = 1'b0;
        @(posedge clk); #2; c_wen_n = 1'b1;
        edges_to_low(2, n);
        chk(n == 7, "R8 chain fall-through edges", n, 7);
        @(posedge clk); #2; c_ren_n = 1'b0; step(1); c_ren_n = 1'b1; step(4);

        // R8: chain depth is the sum
        acc = 0; idle = 0;
        for (int i = 0; i < 10 * D && idle < 20; i++) begin
            c_din = W'(500 + i); c_wen_n = 1'b0;
            if (!c_ir_n) begin acc++; idle = 0; end else idle++;
            step(1);
        end
        c_wen_n = 1'b1; step(4);
        chk(acc == 2 * D, "R8 chain holds sum of depths", acc, 2 * D);

        // R8: free slot bubbles back
        @(posedge clk); #2; c_ren_n = 1'b0;
        @(posedge clk); #2; c_ren_n = 1'b1;
        edges_to_low(3, n);
        chk(n == 5, "R8 chain free-slot edges", n, 5);

        // R3: random traffic through the chain, then drain
        for (int i = 0; i < 400; i++) begin
            c_din = W'($urandom); c_wen_n = $urandom_range(0, 2) == 0;
            c_ren_n = $urandom_range(0, 1) == 0;
            step(1);
        end
        c_wen_n = 1'b1; c_ren_n = 1'b0;
        step(6 * D + 20);
        c_ren_n = 1'b1;
        @(negedge clk);
        chk(q_c.size() == 0 && c_or_n, "R3 chain drained in order", q_c.size(), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule